// File: doc/BRIEF.md
# Butterfly All-Reduce Summation Unit

This block adds up a set of integer lane values and leaves the complete total in every lane. The number of lanes is a power of two. A single start pulse captures all lane inputs at once into a bank of lane registers. The block then runs one exchange stage per clock.

In each stage, every lane adds its own value to the value of a partner lane. The partner index is the lane index XOR a stage distance. The distance begins at half the lane count and halves after each stage. The last stage uses a distance of one.

Each stage has two phases. All lanes first form their sums from the contents held before the stage. The whole bank then commits on the same edge, so no lane ever sees a partner value that was already updated in that stage. After log2(N) stages the block pulses `done` and presents every lane's result. The results stay on the output until the next accepted start.

A client drives the inputs and pulses `start` while `busy` is low. It then waits for `done` and may read any lane. All lanes carry the same total. Addition wraps modulo 2^WIDTH, and there is no overflow indication.

Top module: `bfly_allreduce`

## Requirements
- R1: When `start` is high on a clock edge while `busy` is low, every lane register loads its slice of `lanes_in`. Lane i occupies bits [i*WIDTH +: WIDTH]. On the following cycle `busy` is high and `lanes_out` equals the loaded inputs.
- R2: `done` is high for exactly one cycle. It rises log2(N)+1 cycles after the cycle in which `start` was accepted: one load cycle, then one cycle per stage.
- R3: All sums wrap modulo 2^WIDTH. For example, eight lanes of 16'hFFFF reduce to 16'hFFF8.
- R4: In the cycle where `done` is high, every lane of `lanes_out` equals the wrapped sum of all N inputs.
- R5: A `start` pulse that arrives while `busy` is high has no effect. The reduction in progress finishes with the original data on its original schedule.
- R6: Once `done` has been raised, `lanes_out` holds its values until the next accepted start, whatever `lanes_in` does in the meantime.
- R7: While `rst` (synchronous, active high) is applied, `busy` and `done` are low and every lane reads zero.
- R8: The first stage pairs lane i with lane i XOR N/2 and uses only the old values. One cycle after the load cycle, lane i therefore shows x[i] + x[i XOR N/2].
- R9: `busy` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that loads the inputs and begins a reduction |
| lanes_in | input | LANES*WIDTH | Packed lane inputs; lane i is at [i*WIDTH +: WIDTH] |
| busy | output | 1 | High while exchange stages are running |
| done | output | 1 | One-cycle pulse when the results are final |
| lanes_out | output | LANES*WIDTH | Packed lane register contents, in the same layout as the inputs |

## Verification
The bench builds the block with eight lanes of sixteen bits. This gives three stages, a stage counter that must stop at its final value, and partner distances of four, two and one, so an error in the order of the distances or in the XOR pairing shows up in the first-stage snapshot. Sixteen-bit lanes let the corner vectors reach the wrap: all ones, all 16'h8000, and mixed ones and all-ones patterns that cancel to zero. A stray start during a run, and changes on the input between runs, are aimed at the two hold behaviours.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // distance used by a given stage: lanes/2, lanes/4, ..., 1
    function automatic int stage_dist(input int stg, input int lanes);
        return lanes >> (stg + 1);
    endfunction

    // partner lane index for lane `lane` in stage `stg`
    function automatic int partner_idx(input int lane, input int stg, input int lanes);
        return lane ^ stage_dist(stg, lanes);
    endfunction

    // width of a counter holding values 0..n-1 (at least one bit)
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
    import bfly_pkg::*;
#(
    parameter int STAGES = 3,
    localparam int SW    = cnt_width(STAGES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic [SW-1:0] stage,
    output logic          busy,
    output logic          done
);

    localparam logic [SW-1:0] LAST_STAGE = SW'(STAGES - 1);

    run_state_t state_q;
    logic [SW-1:0] stage_q;
    logic done_q;
    logic at_last;

    assign at_last = (stage_q == LAST_STAGE);
    assign load    = (state_q == ST_IDLE) && start;
    assign step    = (state_q == ST_RUN);
    assign busy    = (state_q == ST_RUN);
    assign stage   = stage_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        stage_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (at_last) begin
                        state_q <= ST_IDLE;
                        stage_q <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        stage_q <= stage_q + SW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: done lasts a single cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: stages advance by one per clock until the last one
    p_stage_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !at_last) |=> (busy && stage == $past(stage) + SW'(1)));

    // R2: the final stage ends the run with done
    p_last_to_done_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && at_last) |=> (done && !busy));

    // R5: a start during a run does not restart the count
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !at_last) |=> (stage == $past(stage) + SW'(1)));

    // R9: busy and done are exclusive
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: rtl/bfly_lane.sv
module bfly_lane
    import bfly_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int STAGES = 3,
    localparam int SW    = cnt_width(STAGES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic                          step,
    input  logic [SW-1:0]                 stage,
    input  logic [WIDTH-1:0]              init_val,
    input  logic [STAGES-1:0][WIDTH-1:0]  partner_vals,
    output logic [WIDTH-1:0]              val
);

    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] partner_pick;
    logic [WIDTH-1:0] pair_sum;

    // phase one: choose the partner of this stage and add from old contents
    always_comb begin
        partner_pick = '0;
        for (int s = 0; s < STAGES; s++) begin
            if (stage == SW'(s)) partner_pick = partner_vals[s];
        end
    end

    assign pair_sum = val_q + partner_pick;   // wraps modulo 2^WIDTH

    // phase two: commit on the shared edge
    always_ff @(posedge clk) begin
        if (rst)       val_q <= '0;
        else if (load) val_q <= init_val;
        else if (step) val_q <= pair_sum;
    end

    assign val = val_q;

    // R1: a load captures the input slice
    p_lane_load_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> (val == $past(init_val)));

    // R6: without load or step the lane keeps its value
    p_lane_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(val));

    // R7: reset clears the lane
    p_lane_reset_r7: assert property (@(posedge clk)
        rst |=> (val == '0));

endmodule

// File: rtl/bfly_allreduce.sv
module bfly_allreduce
    import bfly_pkg::*;
#(
    parameter int LANES = 8,
    parameter int WIDTH = 16,
    localparam int STAGES = $clog2(LANES),
    localparam int SW     = cnt_width(STAGES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LANES*WIDTH-1:0] lanes_in,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*WIDTH-1:0] lanes_out
);

    logic          load;
    logic          step;
    logic [SW-1:0] stage;
    logic [WIDTH-1:0] lane_val [LANES];

    bfly_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .stage (stage),
        .busy  (busy),
        .done  (done)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [STAGES-1:0][WIDTH-1:0] cand;

        for (genvar s = 0; s < STAGES; s++) begin : g_cand
            assign cand[s] = lane_val[partner_idx(i, s, LANES)];
        end

        bfly_lane #(.WIDTH(WIDTH), .STAGES(STAGES)) u_lane (
            .clk          (clk),
            .rst          (rst),
            .load         (load),
            .step         (step),
            .stage        (stage),
            .init_val     (lanes_in[i*WIDTH +: WIDTH]),
            .partner_vals (cand),
            .val          (lane_val[i])
        );

        assign lanes_out[i*WIDTH +: WIDTH] = lane_val[i];
    end

    // observation of lane agreement for the completion check
    logic lanes_agree;
    always_comb begin
        lanes_agree = 1'b1;
        for (int k = 1; k < LANES; k++) begin
            if (lane_val[k] != lane_val[0]) lanes_agree = 1'b0;
        end
    end

    // R4: every lane carries the same total when done is raised
    p_lanes_agree_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> lanes_agree);

    // R6: after done, outputs stay put until a new start is accepted
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(lanes_out));

endmodule

// File: tb/bfly_allreduce_test.sv
module bfly_allreduce_test;

    localparam int NL = 8;
    localparam int WD = 16;
    localparam int VW = NL * WD;
    localparam int NCASE = 6;

    // each entry: {expected total, lane7 .. lane0}
    localparam logic [VW+WD-1:0] CASES [NCASE] = '{
        {16'h0024, 16'd8, 16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1},
        {16'h0000, {8{16'h0000}}},
        {16'hFFF8, {8{16'hFFFF}}},
        {16'h0000, {8{16'h8000}}},
        {16'h1234, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'h1234},
        {16'h0000, {4{16'hFFFF, 16'h0001}}}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [VW-1:0] lanes_in = '0;
    logic          busy;
    logic          done;
    logic [VW-1:0] lanes_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    bfly_allreduce #(.LANES(NL), .WIDTH(WD)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .lanes_in  (lanes_in),
        .busy      (busy),
        .done      (done),
        .lanes_out (lanes_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [WD-1:0] lane_of(input logic [VW-1:0] v, input int i);
        return v[i*WD +: WD];
    endfunction

    function automatic logic [WD-1:0] ref_sum(input logic [VW-1:0] v);
        logic [WD-1:0] acc = '0;
        for (int i = 0; i < NL; i++) acc = acc + lane_of(v, i);
        return acc;
    endfunction

    // start at a negedge, checks at later negedges; stray: extra start mid-run
    task automatic run_case(input logic [VW-1:0] vec, input logic [WD-1:0] exp, input bit stray);
        @(negedge clk);
        lanes_in = vec;
        start    = 1'b1;
        @(negedge clk);                 // load edge has passed
        start = 1'b0;
        check(busy && !done, "R1 busy after load", {busy, done}, 2'b10);
        check(lanes_out == vec, "R1 load", lanes_out, vec);
        @(negedge clk);                 // first stage committed
        for (int i = 0; i < NL; i++) begin
            logic [WD-1:0] e1;
            e1 = lane_of(vec, i) + lane_of(vec, i ^ (NL / 2));
            if (lane_of(lanes_out, i) != e1) begin
                check(1'b0, "R8 first stage", lane_of(lanes_out, i), e1);
            end
        end
        check(1'b1, "R8 first stage", 0, 0);
        if (stray) begin
            lanes_in = ~vec;
            start    = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check(!done && busy, "R5 run continues", {busy, done}, 2'b10);
        @(negedge clk);                 // last stage committed
        check(done && !busy, "R2 done timing / R9", {busy, done}, 2'b01);
        for (int i = 0; i < NL; i++) begin
            check(lane_of(lanes_out, i) == exp, "R4 lane total", lane_of(lanes_out, i), exp);
        end
        @(negedge clk);
        check(!done, "R2 done single cycle", done, 0);
    endtask

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done, "R7 reset flags", {busy, done}, 0);
        check(lanes_out == '0, "R7 reset lanes", lanes_out, 0);
        rst = 1'b0;

        // table walk, with software cross-check of each expected total (R3 wrap cases)
        for (int c = 0; c < NCASE; c++) begin
            logic [VW-1:0] v;
            logic [WD-1:0] e;
            v = CASES[c][VW-1:0];
            e = CASES[c][VW+WD-1:VW];
            check(ref_sum(v) == e, "R3 table total", ref_sum(v), e);
            run_case(v, e, 1'b0);
        end

        // random vectors, some with a stray start mid-run (R5)
        for (int r = 0; r < 12; r++) begin
            logic [VW-1:0] v;
            for (int i = 0; i < NL; i++) v[i*WD +: WD] = WD'($urandom);
            run_case(v, ref_sum(v), r[0]);
        end

        // R6: results held while inputs change without start
        begin
            logic [VW-1:0] v;
            for (int i = 0; i < NL; i++) v[i*WD +: WD] = WD'($urandom);
            run_case(v, ref_sum(v), 1'b0);
            lanes_in = ~v;
            repeat (5) @(negedge clk);
            for (int i = 0; i < NL; i++) begin
                check(lane_of(lanes_out, i) == ref_sum(v), "R6 hold", lane_of(lanes_out, i), ref_sum(v));
            end
            check(!busy && !done, "R6 idle flags", {busy, done}, 0);
        end

        // R3: all-max wrap with stray start
        run_case({NL{16'hFFFF}}, 16'hFFF8, 1'b1);

        // R7: reset in the middle of a run
        @(negedge clk);
        lanes_in = {NL{16'h0101}};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R7 mid-run reset flags", {busy, done}, 0);
        check(lanes_out == '0, "R7 mid-run reset lanes", lanes_out, 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule